// File: doc/BRIEF.md
# Lockable-Entry Translation Lookaside Buffer

This block is a small, fully associative translation cache for a device-side memory management unit. Every slot holds a virtual-side word (tag, page size, valid flag and a preserve flag) and a physical-side word (the physical page base). A combinational lookup port turns a device virtual address into a physical address whenever a valid slot covers it, across four page sizes from 4 KB to 16 MB.

Replacement is steered by a lock register that holds two indices: a floor and a victim pointer. Slots below the floor are kept out of the replacement rotation. Ordinary loads go to the victim slot and the pointer then advances, wrapping back to the floor instead of to zero. Loads flagged as preserved are always placed at the floor, and the floor then moves up by one, so pinned translations pile up at the bottom of the array. Software-style one-cycle commands load a staged entry, read back the slot named by the victim pointer, drop every slot covering one address, or drop everything.

The lock register is readable on the ports and writable through a dedicated strobe, which, combined with the read command, lets software walk every slot.

Top module: `lockable_tlb`

## Requirements
- R1: After reset every slot is invalid, so lookups miss, and the floor, the victim pointer and the busy flag read zero.
- R2: The virtual-side word carries the tag in bits above the page boundary, the valid flag in bit 3, the preserve flag in bit 2 and the page size in bits 1:0 (0 = 4 KB, 1 = 64 KB, 2 = 1 MB, 3 = 16 MB). A lookup hits a valid slot when the address bits above that slot's page boundary equal its tag, and the result keeps the physical base bits above the boundary and the address bits below it.
- R3: When several valid slots cover the lookup address, the lowest-numbered slot supplies the result.
- R4: An ordinary load (preserve flag clear) writes the staged words into the slot named by the victim pointer, then advances the pointer by one; when the advanced value equals the slot count, it takes the value of the floor.
- R5: A preserved load writes the staged words into the slot named by the floor, then raises the floor by one and sets the victim pointer to the new floor.
- R6: A load whose target slot index is not below the slot count (floor full for preserved loads, pointer out of range for ordinary loads) changes no slot and no lock index, and raises the busy output for exactly the following cycle.
- R7: A lock write sets both indices; a read command returns, one cycle later, the two words of the slot named by the victim pointer, with bit 3 of the virtual-side word showing that slot's present validity.
- R8: A single-address flush invalidates every slot whose region satisfies start ≤ address < start + page size and leaves all other slots valid.
- R9: A global flush invalidates every slot and sets the floor and the victim pointer to zero.
- R10: When commands coincide, the global flush wins over a lock write, which wins over a load, which wins over a single-address flush, which wins over a read; the losing commands have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lockWr | input | 1 | Write both lock indices |
| lockBaseIn | input | IDX_W | New floor value |
| lockVictIn | input | IDX_W | New victim pointer value |
| lockBase | output | IDX_W | Current floor |
| lockVict | output | IDX_W | Current victim pointer |
| stageCam | input | ADDR_W | Staged virtual-side word for a load |
| stageRam | input | ADDR_W | Staged physical-side word for a load |
| cmdLoad | input | 1 | Load staged words |
| cmdRead | input | 1 | Read slot at the victim pointer |
| cmdFlushOne | input | 1 | Invalidate slots covering flushAddr |
| cmdFlushAll | input | 1 | Invalidate all slots, clear lock indices |
| flushAddr | input | ADDR_W | Address for the single flush |
| loadBusy | output | 1 | Previous-cycle load was refused |
| rdCam | output | ADDR_W | Virtual-side word of the last read |
| rdRam | output | ADDR_W | Physical-side word of the last read |
| lkAddr | input | ADDR_W | Lookup address |
| lkHit | output | 1 | Lookup hit |
| lkPa | output | ADDR_W | Translated address |

## Verification
The bench builds the block with four slots and 32-bit addresses, so the index width is three bits and the floor can reach the full value of four. That small array lets a handful of loads drive the victim pointer through its wrap, fill the preserved region to the point of refusal, and overlap all four page sizes. Every slot is read back after each phase against a model kept in the bench, and lookups probe both edges of every region.

// File: rtl/ltlb_pkg.sv
`timescale 1ns/1ps
package ltlb_pkg;

  // Bit positions in the virtual-side word that the control decodes.
  localparam int CamValidBit    = 3;
  localparam int CamPreserveBit = 2;

  // Page size code 0..3 selects 4 KB, 64 KB, 1 MB, 16 MB.
  function automatic int unsigned pageShift(input logic [1:0] sizeCode);
    return 32'd12 + 32'd4 * {30'd0, sizeCode};
  endfunction

  // Strobes from control to datapath.
  typedef struct packed {
    logic wrEn;
    logic rdEn;
    logic clrMatch;
    logic clrAll;
  } tlbStrobe_t;

endpackage

// File: rtl/ltlb_ctrl.sv
`timescale 1ns/1ps
module ltlb_ctrl
  import ltlb_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int IDX_W   = $clog2(ENTRIES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lockWr,
  input  logic [IDX_W-1:0] lockBaseIn,
  input  logic [IDX_W-1:0] lockVictIn,
  input  logic             cmdLoad,
  input  logic             loadPreserve,
  input  logic             cmdRead,
  input  logic             cmdFlushOne,
  input  logic             cmdFlushAll,
  output tlbStrobe_t       strb,
  output logic [IDX_W-1:0] slotIdx,
  output logic [IDX_W-1:0] lockBase,
  output logic [IDX_W-1:0] lockVict,
  output logic             loadBusy
);

  logic [IDX_W-1:0] loadSlot;
  logic             slotOut;
  logic             loadTaken;
  logic             loadAccept;
  logic             loadReject;
  logic [IDX_W-1:0] victNext;

  assign loadSlot   = loadPreserve ? lockBase : lockVict;
  assign slotOut    = int'(loadSlot) >= ENTRIES;
  assign loadTaken  = cmdLoad && !cmdFlushAll && !lockWr;
  assign loadAccept = loadTaken && !slotOut;
  assign loadReject = loadTaken && slotOut;
  assign victNext   = (int'(lockVict) + 1 == ENTRIES) ? lockBase : lockVict + 1'b1;

  always_comb begin
    strb    = '0;
    slotIdx = lockVict;
    if (cmdFlushAll) begin
      strb.clrAll = 1'b1;
    end else if (lockWr) begin
      strb = '0;
    end else if (cmdLoad) begin
      if (!slotOut) begin
        strb.wrEn = 1'b1;
        slotIdx   = loadSlot;
      end
    end else if (cmdFlushOne) begin
      strb.clrMatch = 1'b1;
    end else if (cmdRead) begin
      strb.rdEn = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lockBase <= '0;
      lockVict <= '0;
      loadBusy <= 1'b0;
    end else begin
      loadBusy <= loadReject;
      if (cmdFlushAll) begin
        lockBase <= '0;
        lockVict <= '0;
      end else if (lockWr) begin
        lockBase <= lockBaseIn;
        lockVict <= lockVictIn;
      end else if (loadAccept) begin
        if (loadPreserve) begin
          lockBase <= lockBase + 1'b1;
          lockVict <= lockBase + 1'b1;
        end else begin
          lockVict <= victNext;
        end
      end
    end
  end

  assert_flushall_zeroes_lock_R9: assert property (@(posedge clk) disable iff (!rstN)
    cmdFlushAll |=> (lockBase == '0 && lockVict == '0));

  assert_preserve_raises_floor_R5: assert property (@(posedge clk) disable iff (!rstN)
    (loadAccept && loadPreserve) |=> (lockBase == $past(lockBase) + 1'b1 && lockVict == lockBase));

  assert_reject_flags_busy_R6: assert property (@(posedge clk) disable iff (!rstN)
    loadReject |=> (loadBusy && $stable(lockBase) && $stable(lockVict)));

endmodule

// File: rtl/ltlb_store.sv
`timescale 1ns/1ps
module ltlb_store
  import ltlb_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int ADDR_W  = 32,
  parameter int IDX_W   = $clog2(ENTRIES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  tlbStrobe_t        strb,
  input  logic [IDX_W-1:0]  slotIdx,
  input  logic [ADDR_W-1:0] wrCam,
  input  logic [ADDR_W-1:0] wrRam,
  input  logic [ADDR_W-1:0] flushAddr,
  input  logic [ADDR_W-1:0] lkAddr,
  output logic [ADDR_W-1:0] rdCam,
  output logic [ADDR_W-1:0] rdRam,
  output logic              lkHit,
  output logic [ADDR_W-1:0] lkPa
);

  localparam int SLOT_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ADDR_W-1:0] camQ  [ENTRIES];
  logic [ADDR_W-1:0] ramQ  [ENTRIES];
  logic [ADDR_W-1:0] maskE [ENTRIES];
  logic [ENTRIES-1:0] validQ;
  logic [ENTRIES-1:0] lkMatch;
  logic [ENTRIES-1:0] flMatch;
  logic [SLOT_W-1:0]  slot;
  logic               slotOk;

  assign slot   = slotIdx[SLOT_W-1:0];
  assign slotOk = int'(slotIdx) < ENTRIES;

  for (genvar g = 0; g < ENTRIES; g++) begin : gEntry
    assign maskE[g]   = {ADDR_W{1'b1}} << pageShift(camQ[g][1:0]);
    assign lkMatch[g] = validQ[g] && (((lkAddr ^ camQ[g]) & maskE[g]) == '0);
    assign flMatch[g] = validQ[g] && (((flushAddr ^ camQ[g]) & maskE[g]) == '0);
  end

  always_comb begin
    lkHit = 1'b0;
    lkPa  = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (lkMatch[i]) begin
        lkHit = 1'b1;
        lkPa  = (ramQ[i] & maskE[i]) | (lkAddr & ~maskE[i]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strb.wrEn && slotOk) begin
      camQ[slot] <= wrCam;
      ramQ[slot] <= wrRam;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= '0;
    end else if (strb.clrAll) begin
      validQ <= '0;
    end else begin
      if (strb.clrMatch) validQ <= validQ & ~flMatch;
      if (strb.wrEn && slotOk) validQ[slot] <= wrCam[CamValidBit];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdCam <= '0;
      rdRam <= '0;
    end else if (strb.rdEn) begin
      if (slotOk) begin
        rdCam <= {camQ[slot][ADDR_W-1:CamValidBit+1], validQ[slot], camQ[slot][CamValidBit-1:0]};
        rdRam <= ramQ[slot];
      end else begin
        rdCam <= '0;
        rdRam <= '0;
      end
    end
  end

  always_comb begin
    if (rstN && strb.wrEn) assert_write_slot_in_range_R6: assert (slotOk);
  end

  assert_clear_all_misses_R9: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrAll |=> !lkHit);

  assert_flushed_addr_misses_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrMatch && !strb.wrEn) |=> (!($stable(lkAddr) && lkAddr == $past(flushAddr)) || !lkHit));

endmodule

// File: rtl/lockable_tlb.sv
`timescale 1ns/1ps
module lockable_tlb
  import ltlb_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int ADDR_W  = 32,
  parameter int IDX_W   = $clog2(ENTRIES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lockWr,
  input  logic [IDX_W-1:0]  lockBaseIn,
  input  logic [IDX_W-1:0]  lockVictIn,
  output logic [IDX_W-1:0]  lockBase,
  output logic [IDX_W-1:0]  lockVict,
  input  logic [ADDR_W-1:0] stageCam,
  input  logic [ADDR_W-1:0] stageRam,
  input  logic              cmdLoad,
  input  logic              cmdRead,
  input  logic              cmdFlushOne,
  input  logic              cmdFlushAll,
  input  logic [ADDR_W-1:0] flushAddr,
  output logic              loadBusy,
  output logic [ADDR_W-1:0] rdCam,
  output logic [ADDR_W-1:0] rdRam,
  input  logic [ADDR_W-1:0] lkAddr,
  output logic              lkHit,
  output logic [ADDR_W-1:0] lkPa
);

  tlbStrobe_t       strb;
  logic [IDX_W-1:0] slotIdx;

  ltlb_ctrl #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) uCtrl (
    .clk(clk), .rstN(rstN), .lockWr(lockWr), .lockBaseIn(lockBaseIn),
    .lockVictIn(lockVictIn), .cmdLoad(cmdLoad),
    .loadPreserve(stageCam[CamPreserveBit]), .cmdRead(cmdRead),
    .cmdFlushOne(cmdFlushOne), .cmdFlushAll(cmdFlushAll), .strb(strb),
    .slotIdx(slotIdx), .lockBase(lockBase), .lockVict(lockVict),
    .loadBusy(loadBusy)
  );

  ltlb_store #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) uStore (
    .clk(clk), .rstN(rstN), .strb(strb), .slotIdx(slotIdx),
    .wrCam(stageCam), .wrRam(stageRam), .flushAddr(flushAddr),
    .lkAddr(lkAddr), .rdCam(rdCam), .rdRam(rdRam), .lkHit(lkHit), .lkPa(lkPa)
  );

endmodule

// File: tb/sim_lockable_tlb.sv
`timescale 1ns/1ps
module sim_lockable_tlb;
  localparam int N  = 4;
  localparam int AW = 32;
  localparam int IW = $clog2(N + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lockWr = 1'b0;
  logic [IW-1:0] lockBaseIn = '0, lockVictIn = '0;
  logic [IW-1:0] lockBase, lockVict;
  logic [AW-1:0] stageCam = '0, stageRam = '0, flushAddr = '0, lkAddr = '0;
  logic cmdLoad = 1'b0, cmdRead = 1'b0, cmdFlushOne = 1'b0, cmdFlushAll = 1'b0;
  logic loadBusy, lkHit;
  logic [AW-1:0] rdCam, rdRam, lkPa;

  int nRun = 0, nFail = 0;
  bit done = 1'b0;

  logic [AW-1:0] mCam [N];
  logic [AW-1:0] mRam [N];
  bit mVal [N];
  int mBase = 0, mVict = 0;
  bit mBusy = 1'b0;

  always #2.5 clk = ~clk;

  lockable_tlb #(.ENTRIES(N), .ADDR_W(AW)) u0 (
    .clk(clk), .rstN(rstN), .lockWr(lockWr), .lockBaseIn(lockBaseIn),
    .lockVictIn(lockVictIn), .lockBase(lockBase), .lockVict(lockVict),
    .stageCam(stageCam), .stageRam(stageRam), .cmdLoad(cmdLoad),
    .cmdRead(cmdRead), .cmdFlushOne(cmdFlushOne), .cmdFlushAll(cmdFlushAll),
    .flushAddr(flushAddr), .loadBusy(loadBusy), .rdCam(rdCam), .rdRam(rdRam),
    .lkAddr(lkAddr), .lkHit(lkHit), .lkPa(lkPa)
  );

  task automatic chk(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] maskOf(logic [1:0] sz);
    return {AW{1'b1}} << (12 + 4 * int'(sz));
  endfunction

  task automatic clearCmds();
    lockWr = 0; cmdLoad = 0; cmdRead = 0; cmdFlushOne = 0; cmdFlushAll = 0;
  endtask

  task automatic edgeDone();
    @(posedge clk); #1; clearCmds();
  endtask

  task automatic chkLock(string req);
    chk(req, AW'(lockBase), AW'(mBase));
    chk(req, AW'(lockVict), AW'(mVict));
    chk(req, AW'(loadBusy), AW'(mBusy));
  endtask

  task automatic doLoad(logic [AW-1:0] cam, logic [AW-1:0] ram, string req);
    int slot;
    @(negedge clk);
    stageCam = cam; stageRam = ram; cmdLoad = 1;
    edgeDone();
    slot = cam[2] ? mBase : mVict;
    if (slot >= N) mBusy = 1;
    else begin
      mBusy = 0;
      mCam[slot] = cam; mRam[slot] = ram; mVal[slot] = cam[3];
      if (cam[2]) begin mBase = mBase + 1; mVict = mBase; end
      else mVict = (mVict + 1 == N) ? mBase : mVict + 1;
    end
    chkLock(req);
  endtask

  task automatic doLockWr(int b, int v);
    @(negedge clk);
    lockWr = 1; lockBaseIn = IW'(b); lockVictIn = IW'(v);
    edgeDone();
    mBase = b; mVict = v; mBusy = 0;
    chkLock("R7 lock write");
  endtask

  task automatic doRead(int slot);
    doLockWr(mBase, slot);
    @(negedge clk); cmdRead = 1;
    edgeDone();
    if (slot < N) begin
      chk("R7 read cam", rdCam, {mCam[slot][AW-1:4], mVal[slot], mCam[slot][2:0]});
      chk("R7 read ram", rdRam, mRam[slot]);
    end
  endtask

  task automatic readAll();
    for (int s = 0; s < N; s++) begin
      if (mVal[s]) doRead(s);
      else begin
        doRead(s);
        chk("R7 read invalid flag", AW'(rdCam[3]), '0);
      end
    end
  endtask

  task automatic doFlushOne(logic [AW-1:0] a);
    @(negedge clk); cmdFlushOne = 1; flushAddr = a;
    edgeDone();
    for (int i = 0; i < N; i++)
      if (mVal[i] && (((a ^ mCam[i]) & maskOf(mCam[i][1:0])) == '0)) mVal[i] = 0;
    mBusy = 0;
  endtask

  task automatic doFlushAll();
    @(negedge clk); cmdFlushAll = 1;
    edgeDone();
    for (int i = 0; i < N; i++) mVal[i] = 0;
    mBase = 0; mVict = 0; mBusy = 0;
    chkLock("R9 flush all lock");
  endtask

  task automatic chkLookup(logic [AW-1:0] a, string req);
    bit eh; logic [AW-1:0] ep; logic [AW-1:0] m;
    eh = 0; ep = '0;
    for (int i = N - 1; i >= 0; i--) begin
      m = maskOf(mCam[i][1:0]);
      if (mVal[i] && (((a ^ mCam[i]) & m) == '0)) begin
        eh = 1; ep = (mRam[i] & m) | (a & ~m);
      end
    end
    @(negedge clk); lkAddr = a; #1;
    chk(req, AW'(lkHit), AW'(eh));
    if (eh) chk(req, lkPa, ep);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++; nRun++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] tags [4];
    for (int i = 0; i < N; i++) begin mVal[i] = 0; mCam[i] = '0; mRam[i] = '0; end
    tags[0] = 32'h0040_3000; tags[1] = 32'h0041_0000;
    tags[2] = 32'h0050_0000; tags[3] = 32'h0100_0000;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
    @(posedge clk); #1;
    // R1: reset state
    chkLock("R1 reset lock");
    chkLookup(32'h0000_0000, "R1 reset lookup miss");
    chkLookup(32'h1000_0123, "R1 reset lookup miss");

    // R4: ordinary loads, wrap to floor zero, fifth overwrites slot 0
    for (int i = 0; i < 5; i++)
      doLoad(32'h1000_0000 + 32'(i) * 32'h1000 | 32'h8, 32'h8000_0000 + 32'(i) * 32'h3000, "R4 ordinary load");
    for (int i = 0; i < 5; i++) begin
      chkLookup(32'h1000_0000 + 32'(i) * 32'h1000 + 32'h7FF, "R2 4K lookup");
      chkLookup(32'h1000_0000 + 32'(i) * 32'h1000 + 32'hFFF, "R2 4K top");
    end
    readAll();

    // R9: global flush
    doFlushAll();
    chkLookup(32'h1000_1000, "R9 miss after flush");
    chkLookup(32'h1000_4000, "R9 miss after flush");

    // R2: four page sizes, probe edges
    for (int s = 0; s < 4; s++)
      doLoad(tags[s] | 32'h8 | 32'(s), 32'h1111_1000 * 32'(s + 1) & maskOf(2'(s)), "R4 size load");
    for (int s = 0; s < 4; s++) begin
      logic [AW-1:0] sz;
      sz = ~maskOf(2'(s)) + 1;
      chkLookup(tags[s], "R2 region start");
      chkLookup(tags[s] + sz - 1, "R2 region last");
      chkLookup(tags[s] + sz, "R2 region end miss");
      chkLookup(tags[s] - 1, "R2 below region");
      chkLookup(tags[s] + (sz >> 1) + 32'h123, "R2 region middle");
    end
    readAll();

    // R3 and R8: overlap, lowest index wins; single flush selectivity
    doFlushAll();
    doLoad(32'h0500_0000 | 32'hB, 32'h7000_0000, "R4 16M load");
    doLoad(32'h0500_1000 | 32'h8, 32'h1234_5000, "R4 4K load");
    doLoad(32'h0600_0000 | 32'h8, 32'h2000_0000, "R4 other load");
    chkLookup(32'h0500_1234, "R3 lowest index wins");
    chkLookup(32'h0600_0ABC, "R3 single hit");
    doFlushOne(32'h0500_1000);
    chkLookup(32'h0500_1234, "R8 flushed both covering");
    chkLookup(32'h0600_0ABC, "R8 other slot kept");
    readAll();
    doFlushOne(32'h0700_0000);
    chkLookup(32'h0600_0ABC, "R8 no-cover flush keeps slot");

    // R5, R4 wrap to floor, R6 refusal
    doFlushAll();
    doLoad(32'h0800_0000 | 32'hC, 32'h9000_0000, "R5 preserved load");
    for (int i = 1; i < 4; i++)
      doLoad(32'h0900_0000 + 32'(i) * 32'h1000 | 32'h8, 32'hA000_0000 + 32'(i) * 32'h1000, "R4 wrap to floor");
    for (int i = 1; i < 4; i++)
      doLoad(32'h0A00_0000 + 32'(i) * 32'h1000 | 32'hC, 32'hB000_0000 + 32'(i) * 32'h1000, "R5 preserved load");
    doLoad(32'h0B00_0000 | 32'hC, 32'hC000_0000, "R6 floor full refused");
    @(negedge clk); @(posedge clk); #1; mBusy = 0;
    chkLock("R6 busy one cycle");
    doLoad(32'h0B00_1000 | 32'h8, 32'hC000_1000, "R6 pointer out of range refused");
    chkLookup(32'h0B00_0010, "R6 refused load absent");
    chkLookup(32'h0A00_2010, "R5 pinned slot present");
    readAll();
    doLockWr(0, 4);
    doRead(4);
    chk("R7 out-of-range read zero", rdCam, '0);

    // R10: priority
    @(negedge clk); cmdFlushAll = 1; cmdLoad = 1; stageCam = 32'h0C00_0008; stageRam = 32'hD000_0000;
    edgeDone();
    for (int i = 0; i < N; i++) mVal[i] = 0;
    mBase = 0; mVict = 0; mBusy = 0;
    chkLock("R10 flush over load");
    chkLookup(32'h0C00_0000, "R10 flush over load miss");
    @(negedge clk); lockWr = 1; lockBaseIn = 1; lockVictIn = 2; cmdLoad = 1;
    edgeDone();
    mBase = 1; mVict = 2;
    chkLock("R10 lock write over load");
    chkLookup(32'h0C00_0000, "R10 lock write over load miss");
    doLoad(32'h0C00_0008, 32'hD000_0000, "R10 setup load");
    @(negedge clk); cmdLoad = 1; cmdFlushOne = 1; flushAddr = 32'h0C00_0000;
    stageCam = 32'h0D00_0008; stageRam = 32'hE000_0000;
    edgeDone();
    mCam[3] = 32'h0D00_0008; mRam[3] = 32'hE000_0000; mVal[3] = 1; mVict = 1;
    chkLock("R10 load over flush");
    chkLookup(32'h0C00_0000, "R10 flush lost to load");
    chkLookup(32'h0D00_0000, "R10 load taken");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule